// File: doc/BRIEF.md
# Power Island Control Register Block

This block is the register face of a power management unit that looks after 64 peripheral power islands and 64 wake sources. Each island has a 2-bit power state. Software writes the state it wants into four staging words. It then writes a set-configuration command. The block raises a busy flag and counts a fixed latency. It then copies the four staging words into four status words in one step, drops busy, and can flag an interrupt on completion.

Wake sources are gated by enable words. A gated event leaves a sticky status bit that software clears by writing 1. The interrupt register holds an event code, an enable bit, a pending bit cleared by writing 1, and a software-set flag. Reads are combinational from the address. A write is taken on the clock edge where the write strobe is high.

Top module: `pwr_island_regs`

## Requirements
- R1: After reset these read as zero: the status word (byte address 0x00), the command word (0x04), the interrupt word (0x08) and the wake words (0x10 to 0x1C); `irq_o` is 0. The four staging words (0x20 to 0x2C) and the four status words (0x30 to 0x3C) read all ones, so every island is in state 3.
- R2: Island n occupies bits [2(n mod 16)+1 : 2(n mod 16)] of staging word n/16 at byte address 0x20+4(n/16). The matching status word sits at 0x30+4(n/16).
- R3: The set-configuration command has code 0x01 in bits [7:0] of the command word and a nonzero mode in bits [10:9]. Busy is bit 8 of the status word. It reads 1 for exactly CMD_LAT cycles, starting in the cycle after the write, and then reads 0.
- R4: The status words change only when a command completes. At that edge they take the current staging words.
- R5: Writes to the staging words while busy is 1 are dropped.
- R6: A command write while busy is 1 is dropped. It neither extends busy nor replaces the stored command word. It reports event code 2.
- R7: A command whose mode (bits [10:9]) is 0 never raises busy and leaves the status words unchanged. If its bit 8 is set, it reports event code 1 at once.
- R8: A command with a nonzero mode and a code other than 0x01 never raises busy, leaves the status words unchanged, and reports event code 2.
- R9: Events are recorded only while interrupt enable (bit 8 of 0x08) is 1. Recording one sets pending (bit 9) and loads the code into bits [7:0]. A completion is an event only when bit 8 of the command was set.
- R10: `irq_o` equals enable AND (pending OR software flag, bit 10). Writing 1 to bit 9 clears pending. Bits 8 and 10 are plain read/write bits.
- R11: A wake status bit (0x18 for sources 0 to 31, 0x1C for 32 to 63) sets when its source pulses while its enable bit (0x10/0x14) is 1. Writing 1 clears the bit. A newly set bit is an event with code 3.
- R12: When events coincide, the code recorded is 2 over 1, and 1 over 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wake_evt | input | 64 | Wake source event pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts busy cycle by cycle after each command. A counter that is off by one therefore shows up as one cycle too many or too few. It issues a staging write and a second command inside the busy window: a design that let either through would show the new staging value, or a busy period that runs past CMD_LAT. A command written on the very edge where the previous one completes must record code 2 rather than 1, which catches a reversed priority. No-op, unknown-code and interrupt-disabled cases are checked to leave the status words and the pending bit untouched, which exposes a design that commits or records on the wrong condition.

// File: rtl/pwrisl_pkg.sv
package pwrisl_pkg;

  // Word indices (byte address / 4) of the register map
  localparam int WORD_STAT = 0;
  localparam int WORD_CMD  = 1;
  localparam int WORD_ICS  = 2;
  localparam int WORD_WCTL = 4;
  localparam int WORD_WSTS = 6;
  localparam int WORD_SCTL = 8;
  localparam int WORD_SSTS = 12;

  localparam logic [7:0] CODE_SETCFG = 8'h01;

  typedef enum logic [1:0] {
    MODE_NOP = 2'd0,
    MODE_NOW = 2'd1,
    MODE_DLY = 2'd2,
    MODE_TRG = 2'd3
  } cmd_mode_e;

  typedef enum logic [7:0] {
    EV_NONE  = 8'd0,
    EV_DONE  = 8'd1,
    EV_FAULT = 8'd2,
    EV_WAKE  = 8'd3
  } ev_code_e;

  typedef struct packed {
    logic [7:0] code;
    logic       ioc;
    cmd_mode_e  mode;
  } cmd_fields_t;

  // Splits the low 11 bits of a command word into its fields
  function automatic cmd_fields_t split_cmd(input logic [10:0] w);
    cmd_fields_t r;
    r.code = w[7:0];
    r.ioc  = w[8];
    r.mode = cmd_mode_e'(w[10:9]);
    return r;
  endfunction

  // Event code priority: fault, then completion, then wake
  function automatic logic [7:0] pick_code(input logic err, input logic done,
                                           input logic wake);
    if (err)       return EV_FAULT;
    else if (done) return EV_DONE;
    else if (wake) return EV_WAKE;
    return EV_NONE;
  endfunction

  // Island packing arithmetic
  function automatic int isl_word(input int n, input int sw, input int dw);
    return (n * sw) / dw;
  endfunction

  function automatic int isl_lsb(input int n, input int sw, input int dw);
    return (n * sw) % dw;
  endfunction

endpackage

// File: rtl/pwrisl_cmd.sv
module pwrisl_cmd
  import pwrisl_pkg::*;
#(
  parameter int LAT = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          commit,
  output logic          ev_done,
  output logic          ev_err,
  output logic [DW-1:0] cmd_q
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  cmd_fields_t f;
  logic [CW-1:0] cnt;
  logic ioc_q;
  logic accept, launch, bad, noop;

  assign f      = split_cmd(cmd_wdata[10:0]);
  assign accept = cmd_we && !busy;
  assign noop   = accept && (f.mode == MODE_NOP);
  assign launch = accept && (f.mode != MODE_NOP) && (f.code == CODE_SETCFG);
  assign bad    = accept && (f.mode != MODE_NOP) && (f.code != CODE_SETCFG);
  assign commit = busy && (cnt == '0);
  assign ev_err  = (cmd_we && busy) || bad;
  assign ev_done = (commit && ioc_q) || (noop && f.ioc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      ioc_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (accept) cmd_q <= cmd_wdata;
      if (launch) begin
        busy  <= 1'b1;
        cnt   <= CW'(LAT - 1);
        ioc_q <= f.ioc;
      end else if (commit) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrisl_bank.sv
module pwrisl_bank #(
  parameter int            NW  = 4,
  parameter int            DW  = 32,
  parameter logic [DW-1:0] RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    ctl_we,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic             commit,
  output logic [NW*DW-1:0] ctl_flat,
  output logic [NW*DW-1:0] sts_flat
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_flat[g*DW +: DW] <= RST;
        sts_flat[g*DW +: DW] <= RST;
      end else begin
        if (ctl_we[g] && !busy) ctl_flat[g*DW +: DW] <= wdata;
        if (commit)             sts_flat[g*DW +: DW] <= ctl_flat[g*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/pwrisl_wake.sv
module pwrisl_wake #(
  parameter int NSRC = 64,
  parameter int DW   = 32,
  parameter int NWW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NWW-1:0]  en_we,
  input  logic [NWW-1:0]  clr_we,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] en_flat,
  output logic [NSRC-1:0] sts_flat,
  output logic            ev_wake
);
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NWW; g++) begin : g_word
    assign clr_mask[g*DW +: DW] = clr_we[g] ? wdata : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_flat[g*DW +: DW] <= '0;
      else if (en_we[g]) en_flat[g*DW +: DW] <= wdata;
    end
  end

  assign hit     = evt & en_flat;
  assign ev_wake = |(hit & ~sts_flat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_flat <= '0;
    else        sts_flat <= (sts_flat & ~clr_mask) | hit;
  end
endmodule

// File: rtl/pwrisl_irq.sv
module pwrisl_irq
  import pwrisl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ics_we,
  input  logic [2:0]  ics_wbits,
  input  logic        ev_err,
  input  logic        ev_done,
  input  logic        ev_wake,
  output logic [10:0] ics_word,
  output logic        irq,
  output logic        ev_any
);
  logic       ie, pend, sw;
  logic [7:0] code;
  logic       record;

  assign ev_any = ev_err || ev_done || ev_wake;
  assign record = ie && ev_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      pend <= 1'b0;
      sw   <= 1'b0;
      code <= EV_NONE;
    end else begin
      if (ics_we) begin
        ie <= ics_wbits[0];
        sw <= ics_wbits[2];
      end
      if (record) begin
        pend <= 1'b1;
        code <= pick_code(ev_err, ev_done, ev_wake);
      end else if (ics_we && ics_wbits[1]) begin
        pend <= 1'b0;
      end
    end
  end

  assign ics_word = {sw, pend, ie, code};
  assign irq      = ie && (pend || sw);
endmodule

// File: rtl/pwr_island_regs.sv
module pwr_island_regs
  import pwrisl_pkg::*;
#(
  parameter int N_ISL   = 64,
  parameter int ST_W    = 2,
  parameter int DATA_W  = 32,
  parameter int WAKE_N  = 64,
  parameter int ADDR_W  = 8,
  parameter int CMD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WAKE_N-1:0] wake_evt,
  output logic              irq_o
);
  localparam int N_WORDS = isl_word(N_ISL, ST_W, DATA_W);
  localparam int W_WORDS = WAKE_N / DATA_W;
  localparam int WI_W    = ADDR_W - 2;

  logic [WI_W-1:0] wi;
  logic            unused_lsb;
  logic            cmd_we, ics_we;
  logic [N_WORDS-1:0] ctl_we;
  logic [W_WORDS-1:0] wen_we, wclr_we;

  logic busy, commit, ev_done, ev_err, ev_wake, ev_any;
  logic [DATA_W-1:0]         cmd_q;
  logic [N_WORDS*DATA_W-1:0] ctl_flat, sts_flat;
  logic [WAKE_N-1:0]         wen_flat, wsts_flat;
  logic [10:0]               ics_word;

  assign wi         = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  // Write decode
  assign cmd_we = bus_wr && (int'(wi) == WORD_CMD);
  assign ics_we = bus_wr && (int'(wi) == WORD_ICS);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_ctl_dec
    assign ctl_we[g] = bus_wr && (int'(wi) == WORD_SCTL + g);
  end
  for (genvar g = 0; g < W_WORDS; g++) begin : g_wk_dec
    assign wen_we[g]  = bus_wr && (int'(wi) == WORD_WCTL + g);
    assign wclr_we[g] = bus_wr && (int'(wi) == WORD_WSTS + g);
  end

  pwrisl_cmd #(.LAT(CMD_LAT), .DW(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(bus_wdata),
    .busy(busy), .commit(commit), .ev_done(ev_done), .ev_err(ev_err),
    .cmd_q(cmd_q)
  );

  pwrisl_bank #(.NW(N_WORDS), .DW(DATA_W), .RST('1)) u_bank (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(bus_wdata),
    .busy(busy), .commit(commit), .ctl_flat(ctl_flat), .sts_flat(sts_flat)
  );

  pwrisl_wake #(.NSRC(WAKE_N), .DW(DATA_W), .NWW(W_WORDS)) u_wake (
    .clk(clk), .rst_n(rst_n), .en_we(wen_we), .clr_we(wclr_we),
    .wdata(bus_wdata), .evt(wake_evt), .en_flat(wen_flat),
    .sts_flat(wsts_flat), .ev_wake(ev_wake)
  );

  pwrisl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ics_we(ics_we), .ics_wbits(bus_wdata[10:8]),
    .ev_err(ev_err), .ev_done(ev_done), .ev_wake(ev_wake),
    .ics_word(ics_word), .irq(irq_o), .ev_any(ev_any)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (int'(wi) == WORD_STAT) bus_rdata[8] = busy;
    if (int'(wi) == WORD_CMD)  bus_rdata = cmd_q;
    if (int'(wi) == WORD_ICS)  bus_rdata[10:0] = ics_word;
    for (int i = 0; i < W_WORDS; i++) begin
      if (int'(wi) == WORD_WCTL + i) bus_rdata = wen_flat[i*DATA_W +: DATA_W];
      if (int'(wi) == WORD_WSTS + i) bus_rdata = wsts_flat[i*DATA_W +: DATA_W];
    end
    for (int i = 0; i < N_WORDS; i++) begin
      if (int'(wi) == WORD_SCTL + i) bus_rdata = ctl_flat[i*DATA_W +: DATA_W];
      if (int'(wi) == WORD_SSTS + i) bus_rdata = sts_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pwrisl_chk.sv
module pwrisl_chk #(
  parameter int LAT = 4,
  parameter int FW  = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          commit,
  input logic          cmd_we,
  input logic [1:0]    cmd_mode,
  input logic          ics_we,
  input logic          clr_bit,
  input logic          ev_any,
  input logic [10:0]   ics,
  input logic          irq,
  input logic [FW-1:0] ctl_flat,
  input logic [FW-1:0] sts_flat
);
  localparam int RW = $clog2(LAT + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_busy_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) <= LAT);

  p_sts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sts_flat));

  p_sts_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sts_flat == ctl_flat));

  p_ctl_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_flat));

  p_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy && ics[8]) |=> (ics[7:0] == 8'd2 && ics[9]));

  p_noop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_mode == 2'd0) |=> !busy);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ics[8]);

  p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ics_we && clr_bit && !ev_any) |=> !ics[9]);
endmodule

bind pwr_island_regs pwrisl_chk #(.LAT(CMD_LAT), .FW(N_WORDS*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit), .cmd_we(cmd_we),
  .cmd_mode(bus_wdata[10:9]), .ics_we(ics_we), .clr_bit(bus_wdata[9]),
  .ev_any(ev_any), .ics(ics_word), .irq(irq_o), .ctl_flat(ctl_flat),
  .sts_flat(sts_flat)
);

// File: tb/sim_pwr_island_regs.sv
module sim_pwr_island_regs;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] wake_evt = '0;
  logic        irq_o;

  always #10 clk = ~clk;

  pwr_island_regs #(.CMD_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_evt(wake_evt),
    .irq_o(irq_o)
  );

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          fin = 1'b0;
  logic [31:0] ctl_m[4];
  logic [31:0] sts_m[4];

  // Monitor: pops one expectation per cycle, away from the active edge
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s @%h: actual %h expected %h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic idle();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    bus_addr = a;
    it.addr = a; it.exp = e; it.is_irq = 1'b0; it.tag = t;
    sbq.push_back(it);
    @(posedge clk); #2;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.addr = 8'hFF; it.exp = {31'd0, e}; it.is_irq = 1'b1; it.tag = t;
    sbq.push_back(it);
    @(posedge clk); #2;
  endtask

  // Island n: word n>>4, lsb (n&15)<<1
  task automatic set_isl(input int n, input logic [1:0] st);
    int w;
    int b;
    w = n >> 4;
    b = (n & 15) << 1;
    ctl_m[w][b +: 2] = st;
    wr(8'(8'h20 + 4 * w), ctl_m[w]);
  endtask

  task automatic sync_sts();
    for (int i = 0; i < 4; i++) sts_m[i] = ctl_m[i];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      ctl_m[i] = '1;
      sts_m[i] = '1;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    chk(8'h00, 32'h0, "R1 status");
    chk(8'h04, 32'h0, "R1 command");
    chk(8'h08, 32'h0, "R1 irq word");
    chk(8'h10, 32'h0, "R1 wake enable");
    chk(8'h18, 32'h0, "R1 wake status");
    chk(8'h20, 32'hFFFF_FFFF, "R1 staging");
    chk(8'h3C, 32'hFFFF_FFFF, "R1 status word");
    chk_irq(1'b0, "R1 irq_o");

    // R2 packing
    set_isl(5, 2'd0);
    set_isl(50, 2'd1);
    chk(8'h20, 32'hFFFF_F3FF, "R2 island 5");
    chk(8'h2C, 32'hFFFF_FFDF, "R2 island 50");
    chk(8'h30, sts_m[0], "R4 not yet committed");

    // R3 busy window, R9 completion
    wr(8'h08, 32'h100);
    chk(8'h08, 32'h100, "R10 enable readback");
    wr(8'h04, 32'h301);
    for (int k = 0; k < LAT; k++) chk(8'h00, 32'h100, "R3 busy high");
    chk(8'h00, 32'h0, "R3 busy low");
    sync_sts();
    chk(8'h30, sts_m[0], "R4 commit word0");
    chk(8'h3C, sts_m[3], "R4 commit word3");
    chk(8'h08, 32'h301, "R9 done pending");
    chk_irq(1'b1, "R10 irq set");
    chk(8'h04, 32'h301, "R3 command readback");
    wr(8'h08, 32'h300);
    chk(8'h08, 32'h101, "R10 pending cleared");
    chk_irq(1'b0, "R10 irq cleared");

    // R5, R6 writes during busy
    set_isl(20, 2'd2);
    wr(8'h04, 32'h201);
    wr(8'h24, 32'h1234_5678);
    wr(8'h04, 32'h301);
    chk(8'h00, 32'h100, "R6 busy");
    chk(8'h00, 32'h100, "R6 busy");
    chk(8'h00, 32'h0, "R6 busy not extended");
    sync_sts();
    chk(8'h24, 32'hFFFF_FEFF, "R5 staging write dropped");
    chk(8'h34, 32'hFFFF_FEFF, "R4 commit word1");
    chk(8'h08, 32'h302, "R6 error code");
    chk(8'h04, 32'h201, "R6 command kept");
    wr(8'h08, 32'h300);

    // R7 no-op
    set_isl(0, 2'd0);
    wr(8'h04, 32'h101);
    chk(8'h00, 32'h0, "R7 no busy");
    chk(8'h30, sts_m[0], "R7 status unchanged");
    chk(8'h08, 32'h301, "R7 done code");
    wr(8'h08, 32'h300);

    // R8 unknown code
    wr(8'h04, 32'h207);
    chk(8'h00, 32'h0, "R8 no busy");
    chk(8'h08, 32'h302, "R8 error code");
    chk(8'h30, sts_m[0], "R8 status unchanged");
    wr(8'h08, 32'h300);

    // R12 command on the completion edge
    wr(8'h04, 32'h301);
    for (int k = 0; k < LAT - 1; k++) idle();
    wr(8'h04, 32'h301);
    chk(8'h08, 32'h302, "R12 error over done");
    chk(8'h00, 32'h0, "R12 no relaunch");
    sync_sts();
    chk(8'h30, sts_m[0], "R12 commit happened");
    wr(8'h08, 32'h300);

    // R11 wake
    wr(8'h10, 32'h5);
    wake_evt = 64'h3;
    idle();
    wake_evt = '0;
    chk(8'h18, 32'h1, "R11 gated status");
    chk(8'h1C, 32'h0, "R11 upper status");
    chk(8'h08, 32'h303, "R11 wake code");
    chk_irq(1'b1, "R11 irq");
    wr(8'h18, 32'h1);
    chk(8'h18, 32'h0, "R11 cleared");
    wr(8'h08, 32'h300);

    // R10 software flag, R9 disabled recording
    wr(8'h08, 32'h500);
    chk(8'h08, 32'h503, "R10 sw flag");
    chk_irq(1'b1, "R10 sw irq");
    wr(8'h08, 32'h000);
    chk_irq(1'b0, "R10 irq gated");
    chk(8'h08, 32'h003, "R10 all off");
    wr(8'h04, 32'h301);
    repeat (LAT + 1) idle();
    chk(8'h08, 32'h003, "R9 no record when disabled");
    chk(8'h00, 32'h0, "R3 idle after run");

    idle();
    idle();
    if (!fin) begin
      fin = 1'b1;
      finish_run();
    end
  end
endmodule